// File: doc/BRIEF.md
# Triggered ADC Acquisition Sequencer

This block runs a 12-bit parallel ADC on behalf of a data recorder. After reset it sits in standby. A rising edge on the trigger input starts one sweep through a small table of channel codes held in an external synchronous ROM. Every code is range-checked before use. A good code selects the channel and starts one conversion. A bad code is counted and skipped. Each converted sample is staged in an internal FIFO.

The FIFO is not emptied on its own. Only a read request from the storage side starts a drain. The drain sends every staged sample, high byte first, over a valid/ready byte handshake. It keeps going until the FIFO is empty, and it also sends any samples written while it is running. If the FIFO fills, new samples are dropped and a sticky overflow flag is raised.

Top module: `trig_adc_seq`

## Requirements
- R1: After reset `busy_o`, `adc_clk_o`, `st_valid_o` and `overflow_o` are 0 and `err_cnt_o` is 0.
- R2: A 0-to-1 change of `trig_i` while in standby starts a sweep that reads ROM entries 0 to ROM_DEPTH-1 in order. `rom_data_i` must hold the entry for the `rom_addr_o` of the previous cycle. A trigger edge during a sweep has no effect, so no second sweep follows.
- R3: A ROM code below NUM_CH is valid. It is driven on `ch_sel_o` and converted exactly once per sweep, and samples appear in ROM order.
- R4: A ROM code of NUM_CH or above gets no conversion and adds 1 to `err_cnt_o`. The count saturates at 2^ERR_W-1.
- R5: When every ROM entry is invalid, the sweep returns to standby (`busy_o` = 0) and stages no sample.
- R6: Each conversion raises `adc_clk_o` for exactly one cycle. `adc_data_i` is captured at the clock edge that falls PIPE_LAT cycles after the edge at which `adc_clk_o` rose.
- R7: Staged samples never reach the storage port (`st_valid_o` stays 0) until `rd_req_i` is pulsed.
- R8: A `rd_req_i` pulse starts a drain. Each sample leaves as two bytes: first {4'b0, sample[11:8]}, then sample[7:0], in capture order. A byte moves on a cycle with `st_valid_o` and `st_ready_i` both high, and is held stable while `st_ready_i` is low. The drain stops once the FIFO is empty.
- R9: With FIFO_DEPTH samples staged, further samples are dropped and the staged ones are kept unchanged. `overflow_o` is set and stays set until reset.
- R10: A capture and a drain can proceed together. Samples written during a drain are delivered in the same drain, with capture order kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Acquisition trigger, rising edge is used |
| rom_addr_o | output | ROM_AW | Channel-table ROM address |
| rom_data_i | input | CODE_W | Channel code read from the ROM, one cycle after its address |
| adc_clk_o | output | 1 | Conversion clock pulse to the ADC |
| adc_data_i | input | SAMPLE_W | ADC parallel output bus |
| ch_sel_o | output | CH_W | Channel under conversion |
| rd_req_i | input | 1 | Pulse that starts a drain of the FIFO |
| st_valid_o | output | 1 | Storage byte valid |
| st_byte_o | output | 8 | Storage byte |
| st_ready_i | input | 1 | Storage side accepts the byte |
| busy_o | output | 1 | Sweep in progress |
| err_cnt_o | output | ERR_W | Saturating count of invalid channel codes |
| overflow_o | output | 1 | Sticky flag: a sample was dropped on a full FIFO |

## Verification
A FIFO write from a finished conversion and a FIFO read by the drain can fall in the same cycle. The bench provokes this by pulsing the read request in the same cycle as a trigger, while the FIFO already holds a sweep. It also holds storage ready low for five of every six cycles, so the drain is still running as the new sweep's samples arrive. The result is judged at the storage port: the byte stream must carry all eight samples, the old sweep first, each value matching what the bench's ADC model drove, and nothing after them.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_CHECK,
    SEQ_CONV,
    SEQ_NEXT
  } seq_state_t;

  // channel code is usable when it names an existing channel
  function automatic logic code_ok(input int unsigned code, input int unsigned n_ch);
    return code < n_ch;
  endfunction

  // lsb position of byte k when bytes go out most significant first
  function automatic int unsigned byte_lsb(input int unsigned nbytes, input int unsigned k);
    return (nbytes - 1 - k) * 8;
  endfunction

endpackage

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl #(
  parameter int NUM_CH    = 8,
  parameter int CODE_W    = 4,
  parameter int ROM_DEPTH = 4,
  parameter int SAMPLE_W  = 12,
  parameter int PIPE_LAT  = 3,
  parameter int ERR_W     = 8,
  localparam int ROM_AW   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W    = $clog2(PIPE_LAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_rise,
  output logic [ROM_AW-1:0]   rom_addr_o,
  input  logic [CODE_W-1:0]   rom_data_i,
  output logic                adc_clk_o,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic [CH_W-1:0]     ch_sel_o,
  output logic                busy_o,
  output logic                smp_valid_o,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic                bad_code_o,
  output logic [ERR_W-1:0]    err_cnt_o
);
  import acq_pkg::*;

  seq_state_t          state_q;
  logic [ROM_AW-1:0]   idx_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                adc_clk_q;
  logic [CH_W-1:0]     ch_q;
  logic                smp_valid_q;
  logic [SAMPLE_W-1:0] smp_data_q;
  logic [ERR_W-1:0]    err_q;
  logic                code_good;

  assign code_good = code_ok(32'(rom_data_i), NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      idx_q       <= '0;
      cnt_q       <= '0;
      adc_clk_q   <= 1'b0;
      ch_q        <= '0;
      smp_valid_q <= 1'b0;
      smp_data_q  <= '0;
      err_q       <= '0;
    end else begin
      adc_clk_q   <= 1'b0;
      smp_valid_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (trig_rise) begin
            idx_q   <= '0;
            state_q <= SEQ_FETCH;
          end
        end
        SEQ_FETCH: state_q <= SEQ_CHECK;
        SEQ_CHECK: begin
          if (code_good) begin
            ch_q    <= rom_data_i[CH_W-1:0];
            cnt_q   <= '0;
            state_q <= SEQ_CONV;
          end else begin
            if (err_q != '1) err_q <= err_q + 1'b1;
            state_q <= SEQ_NEXT;
          end
        end
        SEQ_CONV: begin
          if (cnt_q == '0) adc_clk_q <= 1'b1;
          if (cnt_q == CNT_W'(PIPE_LAT)) begin
            smp_valid_q <= 1'b1;
            smp_data_q  <= adc_data_i;
            state_q     <= SEQ_NEXT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_NEXT: begin
          if (idx_q == ROM_AW'(ROM_DEPTH - 1)) begin
            state_q <= SEQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SEQ_FETCH;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rom_addr_o  = idx_q;
  assign adc_clk_o   = adc_clk_q;
  assign ch_sel_o    = ch_q;
  assign busy_o      = (state_q != SEQ_IDLE);
  assign smp_valid_o = smp_valid_q;
  assign smp_data_o  = smp_data_q;
  assign bad_code_o  = (state_q == SEQ_CHECK) && !code_good;
  assign err_cnt_o   = err_q;

endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_rd) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data = mem_q[rptr_q];

endmodule

// File: rtl/acq_byte_drain.sv
module acq_byte_drain #(
  parameter int SAMPLE_W = 12,
  localparam int NB      = (SAMPLE_W + 7) / 8,
  localparam int PW      = NB * 8,
  localparam int BI_W    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req_i,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_data,
  output logic                pop_o,
  output logic                draining_o,
  output logic                st_valid_o,
  output logic [7:0]          st_byte_o,
  input  logic                st_ready_i
);
  import acq_pkg::*;

  logic            draining_q;
  logic            valid_q;
  logic [PW-1:0]   word_q;
  logic [BI_W-1:0] bidx_q;

  assign pop_o = draining_q && !valid_q && !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining_q <= 1'b0;
      valid_q    <= 1'b0;
      word_q     <= '0;
      bidx_q     <= '0;
    end else begin
      if (rd_req_i) draining_q <= 1'b1;
      else if (draining_q && !valid_q && fifo_empty) draining_q <= 1'b0;

      if (pop_o) begin
        word_q  <= PW'(fifo_data);
        bidx_q  <= '0;
        valid_q <= 1'b1;
      end else if (valid_q && st_ready_i) begin
        if (bidx_q == BI_W'(NB - 1)) valid_q <= 1'b0;
        else bidx_q <= bidx_q + 1'b1;
      end
    end
  end

  assign draining_o = draining_q;
  assign st_valid_o = valid_q;
  assign st_byte_o  = word_q[byte_lsb(NB, 32'(bidx_q)) +: 8];

endmodule

// File: rtl/trig_adc_seq.sv
module trig_adc_seq #(
  parameter int NUM_CH     = 8,
  parameter int CODE_W     = 4,
  parameter int ROM_DEPTH  = 4,
  parameter int SAMPLE_W   = 12,
  parameter int PIPE_LAT   = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int ERR_W      = 8,
  localparam int ROM_AW    = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_i,
  output logic [ROM_AW-1:0]   rom_addr_o,
  input  logic [CODE_W-1:0]   rom_data_i,
  output logic                adc_clk_o,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic [CH_W-1:0]     ch_sel_o,
  input  logic                rd_req_i,
  output logic                st_valid_o,
  output logic [7:0]          st_byte_o,
  input  logic                st_ready_i,
  output logic                busy_o,
  output logic [ERR_W-1:0]    err_cnt_o,
  output logic                overflow_o
);
  logic                trig_q;
  logic                trig_rise;
  logic                smp_valid;
  logic [SAMPLE_W-1:0] smp_data;
  logic                bad_code_evt;
  logic                fifo_full, fifo_empty;
  logic [SAMPLE_W-1:0] fifo_rdata;
  logic                pop_evt;
  logic                push_evt;
  logic                drop_evt;
  logic                draining;
  logic                ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end
  assign trig_rise = trig_i && !trig_q;

  acq_seq_ctrl #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ROM_DEPTH(ROM_DEPTH),
    .SAMPLE_W(SAMPLE_W), .PIPE_LAT(PIPE_LAT), .ERR_W(ERR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise),
    .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .adc_clk_o(adc_clk_o), .adc_data_i(adc_data_i),
    .ch_sel_o(ch_sel_o), .busy_o(busy_o),
    .smp_valid_o(smp_valid), .smp_data_o(smp_data),
    .bad_code_o(bad_code_evt), .err_cnt_o(err_cnt_o)
  );

  assign push_evt = smp_valid && !fifo_full;
  assign drop_evt = smp_valid && fifo_full;

  acq_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(smp_valid), .wr_data(smp_data),
    .rd_en(pop_evt), .rd_data(fifo_rdata),
    .full(fifo_full), .empty(fifo_empty)
  );

  acq_byte_drain #(.SAMPLE_W(SAMPLE_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i),
    .fifo_empty(fifo_empty), .fifo_data(fifo_rdata),
    .pop_o(pop_evt), .draining_o(draining),
    .st_valid_o(st_valid_o), .st_byte_o(st_byte_o), .st_ready_i(st_ready_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (drop_evt) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

endmodule

// File: rtl/trig_adc_seq_chk.sv
module trig_adc_seq_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_clk,
  input logic             busy,
  input logic             st_valid,
  input logic [7:0]       st_byte,
  input logic             st_ready,
  input logic             draining,
  input logic             drop_evt,
  input logic             overflow,
  input logic             bad_code,
  input logic [ERR_W-1:0] err_cnt
);

  assert_adc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk |=> !adc_clk);

  assert_adc_in_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk |-> busy);

  assert_no_early_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> draining);

  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_byte)));

  assert_overflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_code && (err_cnt != '1)) |=> (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_code |=> $stable(err_cnt));

endmodule

bind trig_adc_seq trig_adc_seq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_clk(adc_clk_o), .busy(busy_o),
  .st_valid(st_valid_o), .st_byte(st_byte_o), .st_ready(st_ready_i),
  .draining(draining), .drop_evt(drop_evt), .overflow(overflow_o),
  .bad_code(bad_code_evt), .err_cnt(err_cnt_o)
);

// File: tb/trig_adc_seq_test.sv
module trig_adc_seq_test;
  localparam int NUM_CH = 8, CODE_W = 4, ROM_DEPTH = 4, SAMPLE_W = 12;
  localparam int PIPE_LAT = 3, FIFO_DEPTH = 8, ERR_W = 3;
  localparam int ERR_MAX = 7;

  // codes (entry 0 in top nibble), expected samples, expected error count after sweep
  localparam logic [23:0] VEC [4] = '{24'h1357_4_0, 24'h092F_2_2, 24'hCDE8_0_6, 24'h664A_3_7};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, trig = 1'b0, rd_req = 1'b0, st_ready = 1'b0;
  logic [1:0]  rom_addr;
  logic [3:0]  rom_data = 4'h0;
  logic        adc_clk;
  logic [11:0] adc_data = 12'hFFF;
  logic [2:0]  ch_sel;
  logic        st_valid, busy, overflow;
  logic [7:0]  st_byte;
  logic [2:0]  err_cnt;

  trig_adc_seq #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ROM_DEPTH(ROM_DEPTH), .SAMPLE_W(SAMPLE_W),
    .PIPE_LAT(PIPE_LAT), .FIFO_DEPTH(FIFO_DEPTH), .ERR_W(ERR_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .adc_clk_o(adc_clk), .adc_data_i(adc_data), .ch_sel_o(ch_sel), .rd_req_i(rd_req),
    .st_valid_o(st_valid), .st_byte_o(st_byte), .st_ready_i(st_ready),
    .busy_o(busy), .err_cnt_o(err_cnt), .overflow_o(overflow)
  );

  int total = 0, bad = 0;
  logic [3:0]  rom_tbl [ROM_DEPTH];
  logic [11:0] exp_q [$];
  int exp_seq = 0, err_exp = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int ch, input int seq);
    return {4'(ch), 8'(seq * 7 + 3)};
  endfunction

  // synchronous ROM model: data follows address by one cycle
  always @(posedge clk) rom_data <= rom_tbl[rom_addr];

  // ADC model: valid word only in the cycle before the capture edge (R6)
  int k = -1, nseq = 0, cur_seq = 0;
  int cur_ch = 0;
  logic adc_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      k = -1; nseq = 0; adc_prev = 1'b0; adc_data = 12'hFFF;
    end else begin
      if (adc_clk) begin
        if (adc_prev) begin
          total++; bad++;
          $display("FAIL R6 adc_clk width actual=%0d expected=%0d", 2, 1);
        end
        k = 0; cur_ch = int'(ch_sel); cur_seq = nseq; nseq++;
      end else if (k >= 0) begin
        k++;
      end
      adc_prev = adc_clk;
      adc_data = (k == PIPE_LAT - 1) ? mk(cur_ch, cur_seq) : 12'hFFF;
    end
  end

  task automatic expect_sweep(input logic [15:0] codes);
    for (int i = 0; i < ROM_DEPTH; i++) begin
      logic [3:0] c;
      c = codes[15 - 4*i -: 4];
      rom_tbl[i] = c;
      if (int'(c) < NUM_CH) begin
        if (exp_q.size() < FIFO_DEPTH) exp_q.push_back(mk(int'(c), exp_seq));
        exp_seq++;
      end else if (err_exp < ERR_MAX) begin
        err_exp++;
      end
    end
  endtask

  task automatic run_sweep(input logic [15:0] codes, input bit retrig);
    int n;
    expect_sweep(codes);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    if (retrig) begin
      repeat (3) @(negedge clk);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    n = 0;
    while (busy && n < 400) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic drain_check(input int nsamp, input int period, input bit go_trig, input string req);
    int got, cyc;
    logic [11:0] s;
    logic [7:0]  eb;
    got = 0; cyc = 0; s = '0;
    while ((cyc == 0 || got < 2 * nsamp) && cyc < 3000) begin
      @(negedge clk);
      rd_req   = (cyc == 0);
      if (go_trig) trig = (cyc == 0);
      st_ready = ((cyc % period) == 0);
      if (st_valid && st_ready) begin
        if (got % 2 == 0) begin
          s  = (exp_q.size() > 0) ? exp_q.pop_front() : 12'h000;
          eb = {4'h0, s[11:8]};
        end else begin
          eb = s[7:0];
        end
        check(st_byte == eb, req, "storage byte", int'(st_byte), int'(eb));
        got++;
      end
      cyc++;
    end
    check(got == 2 * nsamp, req, "byte count", got, 2 * nsamp);
    @(negedge clk); rd_req = 1'b0; trig = 1'b0; st_ready = 1'b0;
    repeat (6) @(negedge clk);
    check(st_valid == 1'b0, "R8", "drain ends when empty", int'(st_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom_tbl[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1", "busy after reset", int'(busy), 0);
    check(adc_clk == 0, "R1", "adc_clk after reset", int'(adc_clk), 0);
    check(st_valid == 0, "R1", "st_valid after reset", int'(st_valid), 0);
    check(err_cnt == 0, "R1", "err_cnt after reset", int'(err_cnt), 0);
    check(overflow == 0, "R1", "overflow after reset", int'(overflow), 0);

    // table walk: R3 order/values, R4 count, R5 all-invalid, R7 hold-off, R8 bytes
    for (int v = 0; v < 4; v++) begin
      run_sweep(VEC[v][23:8], 1'b0);
      check(busy == 0, "R5", "standby after sweep", int'(busy), 0);
      check(int'(err_cnt) == int'(VEC[v][3:0]), "R4", "error count", int'(err_cnt), int'(VEC[v][3:0]));
      repeat (20) @(negedge clk);
      check(st_valid == 0, "R7", "no output before request", int'(st_valid), 0);
      drain_check(int'(VEC[v][7:4]), 1, 1'b0, "R3");
    end

    // R4 saturation: another all-invalid sweep keeps the count at its maximum
    run_sweep(16'hFFFF, 1'b0);
    check(int'(err_cnt) == ERR_MAX, "R4", "saturated error count", int'(err_cnt), ERR_MAX);

    // R2: trigger during a sweep is ignored
    run_sweep(16'h1234, 1'b1);
    repeat (10) @(negedge clk);
    check(busy == 0, "R2", "no second sweep", int'(busy), 0);
    drain_check(4, 2, 1'b0, "R2");

    // R10: drain and capture at once, slow storage side
    run_sweep(16'h0123, 1'b0);
    expect_sweep(16'h4567);
    drain_check(8, 6, 1'b1, "R10");

    // R9: overflow drops extra samples, keeps the first ones
    check(overflow == 0, "R9", "overflow clear before fill", int'(overflow), 0);
    run_sweep(16'h1357, 1'b0);
    run_sweep(16'h1357, 1'b0);
    check(overflow == 0, "R9", "overflow at exactly full", int'(overflow), 0);
    run_sweep(16'h1357, 1'b0);
    check(overflow == 1, "R9", "overflow after drop", int'(overflow), 1);
    drain_check(FIFO_DEPTH, 1, 1'b0, "R9");
    check(overflow == 1, "R9", "overflow sticky", int'(overflow), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule